// File: doc/BRIEF.md
# Double-Error Syndrome Class Judge

This block decides, bit by bit, whether a received bit of a double-error-correcting binary cyclic code is in error. It does this by watching how the number of errors in the word changes. Each cycle it takes the two m-bit syndromes S1 and S3 and forms two checking flags. One flag is set when S1 is zero. The other is set when S3 equals S1 cubed in GF(2^m), reduced modulo the field polynomial. The pair of flags sorts the word into one of four error-count classes: none, one, two, or three or more.

On a strobe in the last cycle of the loading phase, the block latches the initial pair of flags. If that initial class is "three or more", it raises an alarm so that the word can be sent again, and it makes no corrections. In each later check cycle it compares the current class with the latched class. A current class lower than the latched one means the bit under test was in error, so the block asserts a correcting pulse. Otherwise it asserts a cancel pulse, which goes back to the syndrome dividers to undo the trial. When the current flags show that no errors remain, a finished latch stops any further pulses. A clear input resets the block for the next word.

Top module: `dec2_errclass`

## Requirements
- R1: `h_zero` is 1 exactly when `s1` is all zeros; it is combinational from the current inputs.
- R2: `h_cube` is 1 exactly when `s3` equals `s1`·`s1`·`s1` in GF(2^M). The field is built from the polynomial x^M + `FPOLY` (default M=4, FPOLY=4'b0011, i.e. x^4+x+1). Field elements are coefficient vectors with bit i the coefficient of x^i.
- R3: On a clock edge with `load_last`=1 and `clr`=0, the current (`h_zero`,`h_cube`) pair becomes the initial class. It is held through later cycles until `clr`.
- R4: The class code is: 0 when (h_zero,h_cube)=(1,1); 1 when (0,1); 2 when (0,0); 3 when (1,0). If the initial class is 3, `alarm` is 1 from the cycle after the load edge until `clr`, and `corr`/`cancel` stay 0.
- R5: In an enabled check cycle (`check_en`=1, initial class loaded, no alarm, not finished), `corr`=1 exactly when the current class code is less than the initial class code.
- R6: In an enabled check cycle where the current class is not lower than the initial class, `cancel`=1.
- R7: `corr` and `cancel` are never 1 together. Both are 0 when `check_en`=0 and before any initial class has been loaded.
- R8: After an enabled check cycle whose current flags are both 1, `finished` is 1 from the next cycle on. While it is set, `corr` and `cancel` are 0.
- R9: A clock edge with `clr`=1 clears the initial class, `alarm` and `finished`, and takes priority over `load_last`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Clear for a new word |
| load_last | input | 1 | Strobe in the last load cycle; latches the initial class |
| check_en | input | 1 | Marks a check cycle |
| s1 | input | M | Syndrome S1 |
| s3 | input | M | Syndrome S3 |
| h_zero | output | 1 | S1 equals zero |
| h_cube | output | 1 | S3 equals S1 cubed |
| alarm | output | 1 | Uncorrectable initial pattern |
| corr | output | 1 | Correcting bit for the bit under test |
| cancel | output | 1 | Cancel bit returned to the dividers |
| finished | output | 1 | All errors removed |

## Verification
The assertions assume that `load_last` and `check_en` are never high in the same cycle. They also assume that every check cycle follows a load and comes before the next clear, which is the order the decoder's sequencer provides. The bench keeps to this order. For each class pairing it pulses `clr`, then one load, then one or two check cycles, and it drives syndromes only at the falling edge. The flag sweep covers every (S1,S3) pair of the 4-bit field, with cubes taken from a power table that the bench builds itself.

// File: rtl/dec2_pkg.sv
package dec2_pkg;
    typedef struct packed {
        logic init_ok;
        logic init_zero;
        logic init_cube;
        logic alarm;
        logic finished;
    } judge_st_t;

    // class code: 0 none, 1 one, 2 two, 3 three or more
    function automatic logic [1:0] class_of(input logic hz, input logic hc);
        logic [1:0] c;
        case ({hz, hc})
            2'b11:   c = 2'd0;
            2'b01:   c = 2'd1;
            2'b00:   c = 2'd2;
            default: c = 2'd3;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/dec2_gf_cube.sv
module dec2_gf_cube #(
    parameter int M = 4,
    parameter logic [M-1:0] FPOLY = 4'b0011
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] cube
);
    function automatic logic [M-1:0] gmul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [M-1:0] acc;
        logic [M-1:0] sh;
        acc = '0;
        sh  = x;
        for (int i = 0; i < M; i++) begin
            if (y[i]) acc = acc ^ sh;
            sh = sh[M-1] ? ((sh << 1) ^ FPOLY) : (sh << 1);
        end
        return acc;
    endfunction

    logic [M-1:0] sq_d;

    always_comb begin
        sq_d = gmul(a, a);
        cube = gmul(sq_d, a);
    end
endmodule

// File: rtl/dec2_check_bits.sv
module dec2_check_bits #(
    parameter int M = 4,
    parameter logic [M-1:0] FPOLY = 4'b0011
) (
    input  logic [M-1:0] s1,
    input  logic [M-1:0] s3,
    output logic         h_zero,
    output logic         h_cube
);
    logic [M-1:0] cube_d;

    dec2_gf_cube #(.M(M), .FPOLY(FPOLY)) cube_i (
        .a    (s1),
        .cube (cube_d)
    );

    always_comb begin
        h_zero = (s1 == '0);
        h_cube = (s3 == cube_d);
    end

    // R2
    always_comb begin
        if (s1 == '0) h_cube_zero_chk: assert (h_cube == (s3 == '0));
    end
endmodule

// File: rtl/dec2_decide.sv
module dec2_decide
    import dec2_pkg::*;
(
    input  logic active,
    input  logic init_zero,
    input  logic init_cube,
    input  logic h_zero,
    input  logic h_cube,
    output logic corr,
    output logic cancel
);
    logic [1:0] cls_init_d;
    logic [1:0] cls_now_d;
    logic       lower_d;

    always_comb begin
        cls_init_d = class_of(init_zero, init_cube);
        cls_now_d  = class_of(h_zero, h_cube);
        lower_d    = (cls_now_d < cls_init_d);
        corr       = active && lower_d;
        cancel     = active && !lower_d;
    end

    // R7
    always_comb begin
        excl_pulse_chk: assert (!(corr && cancel));
    end
endmodule

// File: rtl/dec2_errclass.sv
module dec2_errclass
    import dec2_pkg::*;
#(
    parameter int M = 4,
    parameter logic [M-1:0] FPOLY = 4'b0011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load_last,
    input  logic         check_en,
    input  logic [M-1:0] s1,
    input  logic [M-1:0] s3,
    output logic         h_zero,
    output logic         h_cube,
    output logic         alarm,
    output logic         corr,
    output logic         cancel,
    output logic         finished
);
    judge_st_t st_d, st_q;
    logic      active_d;

    dec2_check_bits #(.M(M), .FPOLY(FPOLY)) bits_i (
        .s1     (s1),
        .s3     (s3),
        .h_zero (h_zero),
        .h_cube (h_cube)
    );

    always_comb begin
        active_d = check_en && !load_last && st_q.init_ok && !st_q.alarm && !st_q.finished;
    end

    dec2_decide decide_i (
        .active    (active_d),
        .init_zero (st_q.init_zero),
        .init_cube (st_q.init_cube),
        .h_zero    (h_zero),
        .h_cube    (h_cube),
        .corr      (corr),
        .cancel    (cancel)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (load_last) begin
            st_d.init_ok   = 1'b1;
            st_d.init_zero = h_zero;
            st_d.init_cube = h_cube;
            st_d.alarm     = h_zero && !h_cube;
            st_d.finished  = 1'b0;
        end else if (active_d && h_zero && h_cube) begin
            st_d.finished = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        alarm    = st_q.alarm;
        finished = st_q.finished;
    end

    // R4
    alarm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_last && !clr && h_zero && !h_cube) |=> alarm);
    // R4
    alarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> (!corr && !cancel));
    // R8
    done_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> (!corr && !cancel));
    // R8
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (check_en && (corr || cancel) && h_zero && h_cube && !clr) |=> finished);
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!alarm && !finished));
    // R3
    init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load_last) |=> ($stable(st_q.init_zero) && $stable(st_q.init_cube)));
    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!check_en || !st_q.init_ok) |-> (!corr && !cancel));
endmodule

// File: tb/dec2_errclass_tb_top.sv
`timescale 1ns/1ps
module dec2_errclass_tb_top;
    localparam int M = 4;
    localparam logic [M-1:0] FPOLY = 4'b0011;
    localparam int NZ = (1 << M) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, load_last = 1'b0, check_en = 1'b0;
    logic [M-1:0] s1 = '0, s3 = '0;
    logic h_zero, h_cube, alarm, corr, cancel, finished;

    int total = 0;
    int bad = 0;
    logic [M-1:0] pw [0:NZ-1];

    always #2.5 clk = ~clk;

    dec2_errclass #(.M(M), .FPOLY(FPOLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load_last(load_last),
        .check_en(check_en), .s1(s1), .s3(s3), .h_zero(h_zero),
        .h_cube(h_cube), .alarm(alarm), .corr(corr), .cancel(cancel),
        .finished(finished)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [M-1:0] cube_ref(input logic [M-1:0] a);
        logic [M-1:0] r;
        r = '0;
        for (int i = 0; i < NZ; i++)
            if (pw[i] == a) r = pw[(3 * i) % NZ];
        return r;
    endfunction

    // representative syndromes per class code
    task automatic pick(input int c, output logic [M-1:0] a, output logic [M-1:0] b);
        case (c)
            0: begin a = '0;     b = '0; end
            1: begin a = pw[1];  b = pw[3]; end
            2: begin a = pw[0];  b = pw[1]; end
            default: begin a = '0; b = pw[2]; end
        endcase
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    task automatic do_load(input int c);
        logic [M-1:0] a, b;
        pick(c, a, b);
        @(negedge clk); s1 = a; s3 = b; load_last = 1'b1;
        @(negedge clk); load_last = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [M-1:0] x;
        x = 1;
        for (int i = 0; i < NZ; i++) begin
            pw[i] = x;
            x = x[M-1] ? ((x << 1) ^ FPOLY) : (x << 1);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("reset alarm", {7'd0, alarm}, 8'd0);
        chk("reset finished", {7'd0, finished}, 8'd0);
        chk("R7 idle before load", {6'd0, corr, cancel}, 8'd0);

        // R1 R2 sweep of all syndrome pairs
        for (int a = 0; a <= NZ; a++) begin
            for (int b = 0; b <= NZ; b++) begin
                @(negedge clk); s1 = a[M-1:0]; s3 = b[M-1:0]; #1;
                chk("R1 zero flag", {7'd0, h_zero}, {7'd0, a == 0});
                chk("R2 cube flag", {7'd0, h_cube}, {7'd0, b[M-1:0] == cube_ref(a[M-1:0])});
                chk("R7 no check no pulse", {6'd0, corr, cancel}, 8'd0);
            end
        end

        // R5 R6 R4 R8 decision table
        for (int ic = 0; ic < 4; ic++) begin
            for (int cc = 0; cc < 4; cc++) begin
                logic [M-1:0] a, b;
                pulse_clr();
                do_load(ic);
                chk("R4 alarm after load", {7'd0, alarm}, {7'd0, ic == 3});
                pick(cc, a, b);
                s1 = a; s3 = b; check_en = 1'b1; #1;
                if (ic == 3) begin
                    chk("R4 alarm blocks pulses", {6'd0, corr, cancel}, 8'd0);
                end else begin
                    chk("R5 correcting bit", {7'd0, corr}, {7'd0, cc < ic});
                    chk("R6 cancel bit", {7'd0, cancel}, {7'd0, cc >= ic});
                end
                @(negedge clk); #1;
                if (cc == 0 && ic != 3) begin
                    chk("R8 finished set", {7'd0, finished}, 8'd1);
                    chk("R8 finished blocks", {6'd0, corr, cancel}, 8'd0);
                end else begin
                    chk("R8 finished clear", {7'd0, finished}, 8'd0);
                end
                check_en = 1'b0; #1;
                chk("R7 check off", {6'd0, corr, cancel}, 8'd0);
            end
        end

        // R3 initial class held across unrelated cycles
        pulse_clr();
        do_load(2);
        s1 = '0; s3 = '0;
        repeat (5) @(negedge clk);
        begin
            logic [M-1:0] a, b;
            pick(1, a, b);
            s1 = a; s3 = b; check_en = 1'b1; #1;
            chk("R3 held class gives correction", {7'd0, corr}, 8'd1);
            @(negedge clk); check_en = 1'b0;
        end

        // R9 clear wins over load, and clears alarm
        do_load(3);
        chk("R4 alarm raised", {7'd0, alarm}, 8'd1);
        @(negedge clk); clr = 1'b1; load_last = 1'b1; s1 = '0; s3 = pw[2];
        @(negedge clk); clr = 1'b0; load_last = 1'b0; #1;
        chk("R9 clear over load", {7'd0, alarm}, 8'd0);
        check_en = 1'b1; #1;
        chk("R9 nothing loaded after clear", {6'd0, corr, cancel}, 8'd0);
        @(negedge clk); check_en = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule